// File: doc/BRIEF.md
# I2C Bus Master Start-Condition Generator

This block produces the opening Start condition of an I2C transfer when the chip acts as bus master, and watches for a competing master while it does so. Software, or a higher-level sequencer, pulses a go request and supplies a timer reload value. The block then checks that both bus lines are idle. It waits one timing interval with SDA released and pulls SDA low. It waits a second interval and then pulls SCL low. At that point the Start is complete and the bus is held for the next transfer phase.

The bus lines are read through a configurable synchronizer. Each line is driven through an active-high pull-low enable, which suits an open-drain pad. If the bus is found busy when the request arrives, or SCL goes low while the block is still holding SDA high, the block gives up. It sets a collision flag and an interrupt flag and returns to idle without driving either line. If another master pulls SDA low during the first interval, the block stops waiting and pulls SDA low at once. Both flags stay set until a clear pulse arrives. After a successful Start, both lines stay pulled low until a hand-off pulse returns the block to idle.

Top module: `i2c_start_gen`

## Requirements
- R1: A synchronous reset releases both lines, clears `start_en`, clears `coll_flag` and `irq_flag`, and returns the block to idle.
- R2: `sda_in` and `scl_in` pass through `SYNC_STAGES` flip-flops (default 2) before any decision uses them. A line change only affects decisions made at least two clock edges later.
- R3: A `start_go` pulse in idle, with synchronized SDA or SCL low, sets `coll_flag` and `irq_flag` on the next cycle. In that case `start_en` stays 0 and neither line is pulled.
- R4: A `start_go` pulse in idle, with both synchronized lines high, sets `start_en` on the next cycle. It also starts a first interval of `reload`+1 cycles with SDA released; `sda_pull` rises once that interval has elapsed.
- R5: During the first interval, synchronized SCL low while synchronized SDA is high is a collision. `coll_flag` and `irq_flag` are set, `start_en` clears, the lines are released, and the block returns to idle.
- R6: During the first interval, synchronized SDA low (with any SCL level) ends the interval early. `sda_pull` rises on the next cycle.
- R7: Once `sda_pull` rises, a second interval of `reload`+1 cycles follows, and then `scl_pull` rises. SCL seen low during this interval is not a collision.
- R8: When `scl_pull` rises, `start_en` clears and `irq_flag` sets. Both pulls then stay high until a `hand_off` pulse returns the block to idle.
- R9: A `start_go` pulse is ignored while a Start is in progress or the lines are held.
- R10: `coll_flag` and `irq_flag` stay set until `flag_clr` is pulsed. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_go | input | 1 | One-cycle request to generate a Start |
| reload | input | CNT_W | Timer reload; each interval lasts reload+1 cycles |
| sda_in | input | 1 | Level seen on the SDA pad |
| scl_in | input | 1 | Level seen on the SCL pad |
| hand_off | input | 1 | Pulse that releases the held lines and returns to idle |
| flag_clr | input | 1 | Pulse that clears both flags |
| sda_pull | output | 1 | High pulls SDA low |
| scl_pull | output | 1 | High pulls SCL low |
| start_en | output | 1 | Start sequence in progress |
| coll_flag | output | 1 | Sticky bus-collision flag |
| irq_flag | output | 1 | Sticky interrupt flag (completion or collision) |

## Verification
Each result is due a fixed number of edges after its stimulus:
- Flags and `start_en` react one cycle after the `start_go` edge.
- A line change reaches the decision logic only after the two synchronizer edges.
- `sda_pull` rises `reload`+1 cycles after acceptance, or one cycle after a synchronized SDA low.
- `scl_pull` rises a further `reload`+1 cycles later.

The bench keeps a behavioural model that applies the same edge counts to the inputs it drove. It updates the model on each rising edge and compares every output with the model on each falling edge, so a result that arrives one cycle early or late is reported in the cycle where it goes wrong.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // lines released, waiting for a request
      ST_RISE = 2'd1,   // first interval, SDA released
      ST_HOLD = 2'd2,   // second interval, SDA pulled
      ST_HELD = 2'd3    // Start done, both lines pulled
   } start_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   output logic line_s
);
   logic [STAGES-1:0] shreg;

   generate
      if (STAGES < 2) begin : g_bad
         $error("i2c_line_sync needs at least two stages");
      end
   endgenerate

   // Released bus lines read high, so reset to 1.
   always_ff @(posedge clk) begin
      if (rst) shreg <= '1;
      else     shreg <= {shreg[STAGES-2:0], line_in};
   end

   assign line_s = shreg[STAGES-1];
endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             dec,
   input  logic [CNT_W-1:0] reload,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                    cnt <= '0;
      else if (load)              cnt <= reload;
      else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // The sequencer must stop decrementing once the interval has run out.
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      dec |-> !zero); // R7
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
   import i2c_start_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic go,
   input  logic hand_off,
   input  logic flag_clr,
   input  logic sda_s,
   input  logic scl_s,
   input  logic cnt_zero,
   output logic cnt_load,
   output logic cnt_dec,
   output logic sda_pull,
   output logic scl_pull,
   output logic start_en,
   output logic coll_flag,
   output logic irq_flag
);
   start_state_t st, nxt;
   logic set_coll, set_irq, set_en, clr_en;

   always_comb begin
      nxt      = st;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
      set_coll = 1'b0;
      set_irq  = 1'b0;
      set_en   = 1'b0;
      clr_en   = 1'b0;
      case (st)
         ST_IDLE: begin
            if (go) begin
               if (!sda_s || !scl_s) begin
                  set_coll = 1'b1;
                  set_irq  = 1'b1;
               end else begin
                  set_en   = 1'b1;
                  cnt_load = 1'b1;
                  nxt      = ST_RISE;
               end
            end
         end
         ST_RISE: begin
            if (sda_s && !scl_s) begin
               set_coll = 1'b1;
               set_irq  = 1'b1;
               clr_en   = 1'b1;
               nxt      = ST_IDLE;
            end else if (!sda_s || cnt_zero) begin
               cnt_load = 1'b1;
               nxt      = ST_HOLD;
            end else begin
               cnt_dec  = 1'b1;
            end
         end
         ST_HOLD: begin
            if (cnt_zero) begin
               set_irq = 1'b1;
               clr_en  = 1'b1;
               nxt     = ST_HELD;
            end else begin
               cnt_dec = 1'b1;
            end
         end
         ST_HELD: begin
            if (hand_off) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_IDLE;
         start_en  <= 1'b0;
         coll_flag <= 1'b0;
         irq_flag  <= 1'b0;
      end else begin
         st <= nxt;
         if (set_en)      start_en <= 1'b1;
         else if (clr_en) start_en <= 1'b0;
         if (set_coll)      coll_flag <= 1'b1;
         else if (flag_clr) coll_flag <= 1'b0;
         if (set_irq)       irq_flag <= 1'b1;
         else if (flag_clr) irq_flag <= 1'b0;
      end
   end

   assign sda_pull = (st == ST_HOLD) || (st == ST_HELD);
   assign scl_pull = (st == ST_HELD);

   AST_COLL_RELEASES: assert property (@(posedge clk) disable iff (rst)
      $rose(coll_flag) |-> (!sda_pull && !scl_pull && !start_en)); // R5
   AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (rst)
      $rose(scl_pull) |-> $past(sda_pull)); // R7
   AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
      $rose(scl_pull) |-> (irq_flag && !start_en)); // R8
   AST_HOLD_LINES: assert property (@(posedge clk) disable iff (rst)
      (scl_pull && !hand_off) |=> (scl_pull && sda_pull)); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (coll_flag && !flag_clr) |=> coll_flag); // R10
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_go,
   input  logic [CNT_W-1:0] reload,
   input  logic             sda_in,
   input  logic             scl_in,
   input  logic             hand_off,
   input  logic             flag_clr,
   output logic             sda_pull,
   output logic             scl_pull,
   output logic             start_en,
   output logic             coll_flag,
   output logic             irq_flag
);
   localparam int NLINES = 2;   // index 0 = SDA, 1 = SCL

   logic [NLINES-1:0] lines_raw, lines_s;
   logic cnt_load, cnt_dec, cnt_zero;

   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_w
         $error("CNT_W must be between 1 and 16");
      end
   endgenerate

   assign lines_raw = {scl_in, sda_in};

   generate
      for (genvar i = 0; i < NLINES; i++) begin : g_sync
         i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .line_in(lines_raw[i]),
            .line_s (lines_s[i])
         );
      end
   endgenerate

   i2c_baud_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .load  (cnt_load),
      .dec   (cnt_dec),
      .reload(reload),
      .zero  (cnt_zero)
   );

   i2c_start_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .go       (start_go),
      .hand_off (hand_off),
      .flag_clr (flag_clr),
      .sda_s    (lines_s[0]),
      .scl_s    (lines_s[1]),
      .cnt_zero (cnt_zero),
      .cnt_load (cnt_load),
      .cnt_dec  (cnt_dec),
      .sda_pull (sda_pull),
      .scl_pull (scl_pull),
      .start_en (start_en),
      .coll_flag(coll_flag),
      .irq_flag (irq_flag)
   );
endmodule

// File: tb/i2c_start_gen_test.sv
module i2c_start_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int WATCHDOG = 50000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_go = 1'b0;
   logic [W-1:0] reload = '0;
   logic sda_in = 1'b1;
   logic scl_in = 1'b1;
   logic hand_off = 1'b0;
   logic flag_clr = 1'b0;
   logic sda_pull, scl_pull, start_en, coll_flag, irq_flag;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string scen = "R1";

   // reference model state
   int m_st = 0;          // 0 idle, 1 first interval, 2 second interval, 3 held
   int m_cnt = 0;
   bit m_en = 0, m_coll = 0, m_irq = 0;
   bit m_sda1 = 1, m_sda2 = 1, m_scl1 = 1, m_scl2 = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_start_gen #(.CNT_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .start_go(start_go), .reload(reload),
      .sda_in(sda_in), .scl_in(scl_in), .hand_off(hand_off),
      .flag_clr(flag_clr), .sda_pull(sda_pull), .scl_pull(scl_pull),
      .start_en(start_en), .coll_flag(coll_flag), .irq_flag(irq_flag)
   );

   always @(posedge clk) begin
      bit sc, si;
      sc = 0; si = 0;
      if (rst) begin
         m_st = 0; m_cnt = 0; m_en = 0; m_coll = 0; m_irq = 0;
         m_sda1 = 1; m_sda2 = 1; m_scl1 = 1; m_scl2 = 1;
      end else begin
         if (m_st == 0) begin
            if (start_go) begin
               if (!m_sda2 || !m_scl2) begin sc = 1; si = 1; end
               else begin m_st = 1; m_cnt = int'(reload); m_en = 1; end
            end
         end else if (m_st == 1) begin
            if (m_sda2 && !m_scl2) begin sc = 1; si = 1; m_en = 0; m_st = 0; end
            else if (!m_sda2 || m_cnt == 0) begin m_st = 2; m_cnt = int'(reload); end
            else m_cnt = m_cnt - 1;
         end else if (m_st == 2) begin
            if (m_cnt == 0) begin m_st = 3; m_en = 0; si = 1; end
            else m_cnt = m_cnt - 1;
         end else begin
            if (hand_off) m_st = 0;
         end
         if (flag_clr) begin m_coll = 0; m_irq = 0; end
         if (sc) m_coll = 1;
         if (si) m_irq = 1;
         m_sda2 = m_sda1; m_sda1 = sda_in;
         m_scl2 = m_scl1; m_scl1 = scl_in;
      end
   end

   task automatic chk(string what, logic act, bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at cycle %0d", scen, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles > 1) begin
         chk("sda_pull (R4 R6)", sda_pull, m_st >= 2);
         chk("scl_pull (R7 R8)", scl_pull, m_st == 3);
         chk("start_en (R8 R9)", start_en, m_en);
         chk("coll_flag (R3 R5 R10)", coll_flag, m_coll);
         chk("irq_flag (R8 R10)", irq_flag, m_irq);
      end
      if (cycles > WATCHDOG) begin
         fails++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_go();
      start_go = 1'b1; tick(1); start_go = 1'b0;
   endtask

   task automatic release_bus();
      hand_off = 1'b1; tick(1); hand_off = 1'b0;
      flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
      sda_in = 1'b1; scl_in = 1'b1; tick(3);
   endtask

   initial begin
      scen = "R1";
      tick(3);
      rst = 1'b0;
      tick(2);

      scen = "R4 R7 R8";
      reload = 8'd3; pulse_go(); tick(14); release_bus();

      scen = "R4 reload0";
      reload = 8'd0; pulse_go(); tick(6); release_bus();

      scen = "R3 sda";
      sda_in = 1'b0; tick(4); pulse_go(); tick(3);
      scen = "R10 sticky";
      tick(5); flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(2);
      sda_in = 1'b1; tick(3);

      scen = "R3 scl";
      scl_in = 1'b0; tick(4); pulse_go(); tick(3); release_bus();

      scen = "R5";
      reload = 8'd6; pulse_go(); tick(2); scl_in = 1'b0; tick(8); release_bus();

      scen = "R6";
      reload = 8'd6; pulse_go(); tick(2); sda_in = 1'b0; tick(14); release_bus();

      scen = "R7 scl low";
      reload = 8'd4; pulse_go(); tick(7); scl_in = 1'b0; tick(8); release_bus();

      scen = "R9";
      reload = 8'd5; start_go = 1'b1; tick(20); start_go = 1'b0; tick(2); release_bus();

      scen = "R2";
      reload = 8'd5; sda_in = 1'b0; pulse_go(); tick(12); release_bus();

      scen = "R10 set-wins";
      sda_in = 1'b0; tick(4); flag_clr = 1'b1; start_go = 1'b1; tick(1);
      flag_clr = 1'b0; start_go = 1'b0; tick(3); release_bus();

      scen = "R5 R6 R9 random";
      for (int i = 0; i < 3000; i++) begin
         sda_in   = ($urandom % 6) != 0;
         scl_in   = ($urandom % 6) != 0;
         start_go = ($urandom % 5) == 0;
         hand_off = ($urandom % 9) == 0;
         flag_clr = ($urandom % 11) == 0;
         if (($urandom % 40) == 0) reload = W'($urandom % 7);
         tick(1);
      end
      start_go = 1'b0; hand_off = 1'b0; flag_clr = 1'b0;
      tick(2);

      scen = "R1 reset";
      rst = 1'b1; tick(2); rst = 1'b0; tick(2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule